// File: doc/BRIEF.md
# Monitor Channel Handshake Transmitter

This block sends a message of several bytes over the monitor slot of a frame-based serial link. It uses an active-low handshake. Once per frame, the block places one byte and a transmit-handshake bit (MX) on the channel. It reads back the receive-handshake bit (MR) from the far end, the MX line itself and the data line. The data line is open-drain, so it carries the wired-AND of every driver. A frame strobe marks each frame boundary. The block makes every decision on that strobe and holds its outputs between strobes.

Bytes come in through a one-entry push port (valid/ready plus a last-byte marker). The first byte of a message is the address of the target receiver. A transfer begins only when the MX line is seen inactive. Each byte stays on the channel for at least a minimum number of frames. The transmitter moves to the next byte at the first frame boundary where MR goes active. After the last byte is acknowledged, the block releases MX and the data bits. It reports completion once MR has also stayed inactive for the required number of consecutive frames. The block checks every bit it drives as 1 against the readback. If any of those bits reads back as 0, the transfer is aborted.

Top module: `mon_handshake_tx`

## Requirements
- R1: After reset, mx_n_o is 1, mon_tx_o is all ones, in_ready_o is 1, and abort_o and done_o are 0.
- R2: A transfer starts only on a strobe where a byte is held and mx_rx_n_i is 1. After that strobe, mx_n_o is 0 and mon_tx_o carries the first pushed byte. If mx_rx_n_i is 0, the block stays idle.
- R3: A byte stays on mon_tx_o for at least MIN_REPS (default 2) frames. An MR falling edge seen at the first strobe does not advance it.
- R4: The block advances only on an MR falling edge: mr_n_i is 1 at one strobe and 0 at the next, with MX active. If MR stays low across strobes, there is no advance.
- R5: The block anticipates the acknowledge. The next byte appears on mon_tx_o directly after the strobe that sees the qualifying MR falling edge.
- R6: After the last byte is acknowledged, mx_n_o is 1 and mon_tx_o is all ones. A strobe with mr_n_i at 0 restarts the end-of-message count. done_o pulses for one cycle after EOM_FRAMES (default 2) consecutive strobes with mr_n_i at 1, and the block returns to idle.
- R7: A collision is a strobe while sending where any bit driven 1 reads back 0 on mon_rx_i. On a collision the block pulses abort_o for one cycle, sets mx_n_o to 1 and mon_tx_o to all ones, returns to idle and discards the held byte, which sets in_ready_o back to 1. A 0 read back on a bit driven 0 is not a collision.
- R8: mon_tx_o, mx_n_o and the acknowledge state change only on cycles where frame_stb_i is 1.
- R9: in_ready_o is 0 while a byte is held. A byte is taken only when in_valid_i and in_ready_o are both 1.
- R10: If an acknowledge arrives while no next byte is held, the current byte keeps repeating. The block advances at the first strobe after the next byte is pushed, with no further MR edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb_i | input | 1 | One-cycle frame boundary strobe |
| in_data_i | input | DATA_W | Byte pushed by the user side |
| in_last_i | input | 1 | Pushed byte ends the message |
| in_valid_i | input | 1 | Push request |
| in_ready_o | output | 1 | Holding slot free |
| mon_tx_o | output | DATA_W | Monitor byte driven; 1 means released |
| mx_n_o | output | 1 | Transmit handshake bit, active low |
| mon_rx_i | input | DATA_W | Readback of the wired-AND data line |
| mx_rx_n_i | input | 1 | Readback of the MX line |
| mr_n_i | input | 1 | Receive handshake bit from the receiver, active low |
| abort_o | output | 1 | One-cycle collision abort pulse |
| done_o | output | 1 | One-cycle end-of-message complete pulse |

## Verification
The bench acts as the receiver. Its first acknowledge comes one frame early, and a design that ignored the repeat minimum would skip ahead on it. It holds MR low across several frames, which a level-triggered design would treat as repeated acknowledges, and it acknowledges before the next byte is pushed, so a design that lost that acknowledge would hang. During the end-of-message phase it reactivates MR once, which catches a counter that does not restart. Collision cases pull low a bit the block drives 0 (which must not abort) and then a bit it drives 1 (which must abort and flush the queued byte). A busy MX line must hold off the start.

// File: rtl/mon_tx_pkg.sv
package mon_tx_pkg;

   typedef enum logic [1:0] {
      MTX_IDLE = 2'd0,
      MTX_SEND = 2'd1,
      MTX_EOM  = 2'd2
   } mtx_state_e;

   function automatic int unsigned width_for(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/mon_hold.sv
module mon_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_last,
   input  logic              push_valid,
   output logic              push_ready,
   input  logic              take,
   input  logic              flush,
   output logic              slot_valid,
   output logic [DATA_W-1:0] slot_data,
   output logic              slot_last
);

   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic              last_q;

   assign push_ready = ~valid_q;
   assign slot_valid = valid_q;
   assign slot_data  = data_q;
   assign slot_last  = last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '1;
         last_q  <= 1'b0;
      end else if (flush || take) begin
         valid_q <= 1'b0;
      end else if (push_valid && ~valid_q) begin
         valid_q <= 1'b1;
         data_q  <= push_data;
         last_q  <= push_last;
      end
   end

endmodule

// File: rtl/mon_collide.sv
module mon_collide #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] driven,
   input  logic [DATA_W-1:0] sensed,
   output logic              hit
);

   logic [DATA_W-1:0] bit_clash;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign bit_clash[b] = driven[b] & ~sensed[b];
   end

   assign hit = |bit_clash;

endmodule

// File: rtl/mon_eom_ctr.sv
module mon_eom_ctr #(
   parameter int unsigned EOM_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   input  logic mr_idle,
   output logic reached
);
   import mon_tx_pkg::*;

   localparam int unsigned CNT_W = width_for(EOM_FRAMES);

   logic [CNT_W-1:0] cnt_q;

   assign reached = step && mr_idle && (cnt_q == CNT_W'(EOM_FRAMES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         if (!mr_idle) cnt_q <= '0;
         else if (!reached) cnt_q <= cnt_q + 1'b1;
         else cnt_q <= '0;
      end
   end

endmodule

// File: rtl/mon_handshake_tx.sv
module mon_handshake_tx #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned MIN_REPS   = 2,
   parameter int unsigned EOM_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_last_i,
   input  logic              in_valid_i,
   output logic              in_ready_o,
   output logic [DATA_W-1:0] mon_tx_o,
   output logic              mx_n_o,
   input  logic [DATA_W-1:0] mon_rx_i,
   input  logic              mx_rx_n_i,
   input  logic              mr_n_i,
   output logic              abort_o,
   output logic              done_o
);
   import mon_tx_pkg::*;

   localparam int unsigned REP_W   = width_for(MIN_REPS);
   localparam int unsigned REP_MAX = (MIN_REPS > 0) ? MIN_REPS - 1 : 0;

   if (DATA_W < 1) begin : g_bad_width
      $error("mon_handshake_tx: DATA_W must be at least 1");
   end
   if (MIN_REPS < 1) begin : g_bad_reps
      $error("mon_handshake_tx: MIN_REPS must be at least 1");
   end
   if (EOM_FRAMES < 2) begin : g_bad_eom
      $error("mon_handshake_tx: EOM_FRAMES must be at least 2");
   end

   mtx_state_e        st_q;
   logic [DATA_W-1:0] tx_q;
   logic              mx_q;
   logic              mr_prev_q;
   logic              acked_q;
   logic              cur_last_q;
   logic [REP_W-1:0]  rep_q;
   logic              abort_q;
   logic              done_q;

   logic              slot_valid;
   logic [DATA_W-1:0] slot_data;
   logic              slot_last;
   logic              clash;
   logic              eom_reached;

   logic              in_send;
   logic              rep_ok;
   logic              mr_fall;
   logic              ack_now;
   logic              start_go;
   logic              next_go;
   logic              finish_go;
   logic              abort_go;
   logic              take;

   mon_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_data  (in_data_i),
      .push_last  (in_last_i),
      .push_valid (in_valid_i),
      .push_ready (in_ready_o),
      .take       (take),
      .flush      (abort_go),
      .slot_valid (slot_valid),
      .slot_data  (slot_data),
      .slot_last  (slot_last)
   );

   mon_collide #(.DATA_W(DATA_W)) u_collide (
      .driven (tx_q),
      .sensed (mon_rx_i),
      .hit    (clash)
   );

   mon_eom_ctr #(.EOM_FRAMES(EOM_FRAMES)) u_eom (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (finish_go),
      .step    (frame_stb_i && (st_q == MTX_EOM)),
      .mr_idle (mr_n_i),
      .reached (eom_reached)
   );

   always_comb begin
      in_send   = (st_q == MTX_SEND);
      rep_ok    = (rep_q >= REP_W'(REP_MAX));
      mr_fall   = mr_prev_q && !mr_n_i;
      ack_now   = acked_q || (mr_fall && rep_ok);
      abort_go  = frame_stb_i && in_send && clash;
      start_go  = frame_stb_i && (st_q == MTX_IDLE) && slot_valid && mx_rx_n_i;
      next_go   = frame_stb_i && in_send && !clash && ack_now &&
                  !cur_last_q && slot_valid;
      finish_go = frame_stb_i && in_send && !clash && ack_now && cur_last_q;
      take      = start_go || next_go;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= MTX_IDLE;
         tx_q       <= '1;
         mx_q       <= 1'b1;
         mr_prev_q  <= 1'b1;
         acked_q    <= 1'b0;
         cur_last_q <= 1'b0;
         rep_q      <= '0;
         abort_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         abort_q <= 1'b0;
         done_q  <= 1'b0;
         if (frame_stb_i) begin
            mr_prev_q <= mr_n_i;
            unique case (st_q)
               MTX_IDLE: begin
                  if (start_go) begin
                     st_q       <= MTX_SEND;
                     tx_q       <= slot_data;
                     cur_last_q <= slot_last;
                     mx_q       <= 1'b0;
                     rep_q      <= '0;
                     acked_q    <= 1'b0;
                  end
               end
               MTX_SEND: begin
                  if (abort_go) begin
                     st_q    <= MTX_IDLE;
                     tx_q    <= '1;
                     mx_q    <= 1'b1;
                     acked_q <= 1'b0;
                     abort_q <= 1'b1;
                  end else if (finish_go) begin
                     st_q    <= MTX_EOM;
                     tx_q    <= '1;
                     mx_q    <= 1'b1;
                     acked_q <= 1'b0;
                  end else if (next_go) begin
                     tx_q       <= slot_data;
                     cur_last_q <= slot_last;
                     rep_q      <= '0;
                     acked_q    <= 1'b0;
                  end else begin
                     acked_q <= ack_now;
                     if (!rep_ok) rep_q <= rep_q + 1'b1;
                  end
               end
               MTX_EOM: begin
                  if (eom_reached) begin
                     st_q   <= MTX_IDLE;
                     done_q <= 1'b1;
                  end
               end
               default: begin
                  st_q <= MTX_IDLE;
                  tx_q <= '1;
                  mx_q <= 1'b1;
               end
            endcase
         end
      end
   end

   assign mon_tx_o = tx_q;
   assign mx_n_o   = mx_q;
   assign abort_o  = abort_q;
   assign done_o   = done_q;

endmodule

// File: rtl/mon_handshake_tx_chk.sv
module mon_handshake_tx_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_stb_i,
   input logic              in_valid_i,
   input logic              in_ready_o,
   input logic [DATA_W-1:0] mon_tx_o,
   input logic              mx_n_o,
   input logic              mx_rx_n_i,
   input logic              mr_n_i,
   input logic              abort_o,
   input logic              done_o,
   input logic              acked
);

   assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb_i |=> ($stable(mon_tx_o) && $stable(mx_n_o)));

   assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (mx_n_o && (mon_tx_o == '1)));

   assert_done_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (mx_n_o && (mon_tx_o == '1)));

   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mx_n_o) |-> $past(frame_stb_i && mx_rx_n_i));

   assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready_o && !frame_stb_i) |=> !in_ready_o);

   assert_no_level_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb_i && !mx_n_o && mr_n_i && !acked) |=> ($stable(mon_tx_o) || abort_o));

   assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({abort_o, done_o}));

endmodule

bind mon_handshake_tx mon_handshake_tx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_stb_i (frame_stb_i),
   .in_valid_i  (in_valid_i),
   .in_ready_o  (in_ready_o),
   .mon_tx_o    (mon_tx_o),
   .mx_n_o      (mx_n_o),
   .mx_rx_n_i   (mx_rx_n_i),
   .mr_n_i      (mr_n_i),
   .abort_o     (abort_o),
   .done_o      (done_o),
   .acked       (acked_q)
);

// File: tb/mon_handshake_tx_bench.sv
`timescale 1ns/1ps
module mon_handshake_tx_bench;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_last = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] mon_tx;
   logic          mx_n;
   logic [DW-1:0] jam = '1;
   logic          other_mx = 1'b1;
   logic          mr_n = 1'b1;
   logic          abort_p;
   logic          done_p;
   logic [DW-1:0] mon_rx;
   logic          mx_rx_n;

   int checks = 0;
   int failures = 0;
   logic [DW-1:0] exp_q[$];
   logic prev_mx = 1'b1;

   assign mon_rx  = mon_tx & jam;
   assign mx_rx_n = mx_n & other_mx;

   always #2.5 clk = ~clk;

   mon_handshake_tx u_mon_handshake_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_stb_i (frame_stb),
      .in_data_i   (in_data),
      .in_last_i   (in_last),
      .in_valid_i  (in_valid),
      .in_ready_o  (in_ready),
      .mon_tx_o    (mon_tx),
      .mx_n_o      (mx_n),
      .mon_rx_i    (mon_rx),
      .mx_rx_n_i   (mx_rx_n),
      .mr_n_i      (mr_n),
      .abort_o     (abort_p),
      .done_o      (done_p)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_byte(input logic [DW-1:0] d, input logic last);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_data  = d;
      in_last  = last;
      in_valid = 1'b1;
      exp_q.push_back(d);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // monitor: a new byte on the channel is popped from the scoreboard
   task automatic monitor(input bit adv_exp);
      if (!mx_n && (prev_mx || adv_exp)) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 scoreboard empty", mon_tx, 0);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(mon_tx == e, "R2/R5 byte order", mon_tx, e);
         end
      end
      prev_mx = mx_n;
   endtask

   task automatic frame(input logic mr, input bit adv_exp);
      mr_n = mr;
      @(negedge clk);
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      monitor(adv_exp);
   endtask

   initial begin : watchdog
      #(150000 * 5);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mx_n == 1'b1, "R1 mx_n", mx_n, 1);
      chk(mon_tx == 8'hFF, "R1 mon_tx", mon_tx, 8'hFF);
      chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
      chk(!abort_p && !done_p, "R1 pulses", {abort_p, done_p}, 0);

      // R9 holding slot
      push_byte(8'h81, 1'b0);
      chk(in_ready == 1'b0, "R9 ready low when full", in_ready, 0);

      // R2 busy MX line blocks start
      other_mx = 1'b0;
      frame(1'b1, 1'b0);
      chk(mx_n == 1'b1 && mon_tx == 8'hFF, "R2 no start while MX busy", {mx_n, mon_tx}, 9'h1FF);
      other_mx = 1'b1;
      frame(1'b1, 1'b0);
      chk(mx_n == 1'b0, "R2 start", mx_n, 0);

      push_byte(8'h12, 1'b0);
      // R3 early acknowledge is ignored
      frame(1'b0, 1'b0);
      chk(mon_tx == 8'h81, "R3 byte repeated after early ack", mon_tx, 8'h81);
      frame(1'b1, 1'b0);
      chk(mon_tx == 8'h81, "R3 byte repeated", mon_tx, 8'h81);

      // R8 outputs hold between strobes
      mr_n = 1'b0;
      jam  = 8'h00;
      repeat (4) @(negedge clk);
      chk(mon_tx == 8'h81 && mx_n == 1'b0 && !abort_p, "R8 stable between strobes", mon_tx, 8'h81);
      jam = '1;

      // R5 anticipated advance on MR falling edge
      frame(1'b0, 1'b1);
      chk(mon_tx == 8'h12, "R5 next byte after edge", mon_tx, 8'h12);

      // R4 MR held low: no advance
      frame(1'b0, 1'b0);
      chk(mon_tx == 8'h12, "R4 level low no advance", mon_tx, 8'h12);
      frame(1'b0, 1'b0);
      chk(mon_tx == 8'h12, "R4 level low no advance again", mon_tx, 8'h12);
      frame(1'b1, 1'b0);

      // R10 acknowledge with no next byte held
      frame(1'b0, 1'b0);
      chk(mon_tx == 8'h12 && mx_n == 1'b0, "R10 repeats while starved", mon_tx, 8'h12);
      push_byte(8'h34, 1'b1);
      frame(1'b0, 1'b1);
      chk(mon_tx == 8'h34, "R10 advance once byte pushed", mon_tx, 8'h34);

      // R6 end of message
      frame(1'b1, 1'b0);
      frame(1'b0, 1'b0);
      chk(mx_n == 1'b1 && mon_tx == 8'hFF, "R6 release after last ack", {mx_n, mon_tx}, 9'h1FF);
      frame(1'b1, 1'b0);
      chk(done_p == 1'b0, "R6 no done after one idle frame", done_p, 0);
      frame(1'b0, 1'b0);
      chk(done_p == 1'b0, "R6 MR active restarts count", done_p, 0);
      frame(1'b1, 1'b0);
      chk(done_p == 1'b0, "R6 no done yet", done_p, 0);
      frame(1'b1, 1'b0);
      chk(done_p == 1'b1, "R6 done pulse", done_p, 1);
      @(negedge clk);
      chk(done_p == 1'b0, "R6 done one cycle", done_p, 0);
      chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

      // R7 collision handling
      push_byte(8'hA5, 1'b1);
      frame(1'b1, 1'b0);
      chk(mon_tx == 8'hA5 && mx_n == 1'b0, "R7 second message starts", mon_tx, 8'hA5);
      jam = 8'hBF;
      frame(1'b1, 1'b0);
      chk(!abort_p && mon_tx == 8'hA5, "R7 zero on driven-0 bit is no collision", abort_p, 0);
      jam = '1;
      push_byte(8'h77, 1'b1);
      jam = 8'hFB;
      frame(1'b1, 1'b0);
      chk(abort_p == 1'b1, "R7 abort pulse", abort_p, 1);
      chk(mx_n == 1'b1 && mon_tx == 8'hFF, "R7 release on abort", {mx_n, mon_tx}, 9'h1FF);
      chk(in_ready == 1'b1, "R7 held byte discarded", in_ready, 1);
      exp_q.delete();
      jam = '1;
      @(negedge clk);
      chk(abort_p == 1'b0, "R7 abort one cycle", abort_p, 0);
      frame(1'b1, 1'b0);
      chk(mx_n == 1'b1, "R7 no restart after abort", mx_n, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule